// File: doc/BRIEF.md
# Reset-Time Clock Mode Selector

This block settles how an audio codec is clocked, once for each reset. While reset is held, a free-running detector clock samples the external reference-clock input and counts its edges. When reset is released, the block combines two facts into one of four clocking modes: whether that input carried a live clock, and the level of the two active-low ID strap pins. The mode then stays fixed until reset is asserted again.

From the chosen mode the block drives several outputs:
- the codec's role, primary or secondary;
- the enable and bypass controls of the external PLL;
- a divider-ratio select for that PLL;
- the direction of the bit-clock pin;
- a bit clock at half the system clock rate, produced only when the codec is primary;
- the two-bit ID value shown in the extended audio and modem ID register fields.

The detector clock `clk` also serves as the system clock from which the bit clock is divided.

Top module: `clk_mode_select`

## Requirements
- R1: If at least MIN_EDGES rising edges of `ref_clk_i` fall inside one detector window of WIN_CYCLES `clk` cycles during reset, the clock counts as present at release, and `primary_o` is 1 whatever the straps are.
- R2: Clock present and straps `id_n_i` = 2'b11: `mode_o` = 2'b01 (PLL bypass), `pll_bypass_o` = 1, `pll_en_o` = 0, `pll_div_sel_o` = 2'b00.
- R3: Clock present and straps not 2'b11: `mode_o` = 2'b10 (PLL), `pll_en_o` = 1, `pll_bypass_o` = 0, and `pll_div_sel_o` equals the strap pin levels.
- R4: Clock absent and straps = 2'b11: `mode_o` = 2'b00 (crystal primary), `primary_o` = 1, PLL enable and bypass both 0, `pll_div_sel_o` = 2'b00.
- R5: Clock absent and either strap low: `mode_o` = 2'b11 (secondary), `primary_o` = 0, `bclk_oe_o` = 0, `bclk_o` held low.
- R6: `id_rpt_o` is 2'b00 in modes 2'b01 and 2'b10. In modes 2'b00 and 2'b11 it is the bitwise inverse of the strap levels latched at release.
- R7: Once reset is released, all mode outputs stay unchanged until reset is asserted again. Changes on `id_n_i` or `ref_clk_i` after release are ignored.
- R8: When primary, `bclk_o` toggles on every `clk` edge, starting low on the release edge and first going high one edge later. It is low while reset is held.
- R9: While `rst` is high, the outputs take their reset values from the next edge on: `mode_o` = 2'b11, and `primary_o`, `pll_en_o`, `pll_bypass_o`, `bclk_oe_o`, `bclk_o`, `id_rpt_o` and `pll_div_sel_o` all 0.
- R10: Every new reset release chooses the mode afresh from the current clock activity and straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running detector and system clock |
| rst | input | 1 | Synchronous active-high reset; the mode is latched on its deassertion |
| ref_clk_i | input | 1 | External reference clock, asynchronous to `clk` |
| id_n_i | input | 2 | Active-low ID strap pins |
| mode_o | output | 2 | Clocking mode: 00 crystal, 01 PLL bypass, 10 PLL, 11 secondary |
| primary_o | output | 1 | 1 when the codec is primary |
| pll_en_o | output | 1 | External PLL enable |
| pll_bypass_o | output | 1 | Reference clock used directly, PLL bypassed |
| bclk_oe_o | output | 1 | 1 drives the bit-clock pin; 0 makes it an input |
| bclk_o | output | 1 | Generated bit clock, `clk`/2 |
| id_rpt_o | output | 2 | ID value for the extended ID register fields |
| pll_div_sel_o | output | 2 | Encoded PLL divider-ratio select |

## Verification
The assertions assume that `rst` is synchronous to `clk` and that the straps are steady for more than the synchroniser depth around the release edge. They also assume the reference clock is either running steadily or absent for at least two detector windows before release, and that its half period is several `clk` cycles long, so no edge is lost in sampling. The stimulus meets these assumptions:
- it changes `ref_clk_i` only on falling `clk` edges, with half periods of 3 or 20 cycles or none at all;
- it sets the straps and the reference clock at the moment reset is asserted;
- it holds reset for four windows before release.

Only after release does the stimulus deliberately break these conditions, to show that late activity on the straps and the reference clock has no effect.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [1:0] {
    MODE_XTAL    = 2'b00,
    MODE_PLL_BYP = 2'b01,
    MODE_PLL     = 2'b10,
    MODE_SEC     = 2'b11
  } clk_mode_e;

  localparam logic [1:0] STRAPS_HIGH = 2'b11;
endpackage

// File: rtl/clkmode_sync.sv
// Multi-stage synchroniser for slow or asynchronous level inputs.
module clkmode_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int s = 1; s < STAGES; s++) begin
      stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkmode_actdet.sv
// Counts rising edges of the synchronised reference within fixed windows.
module clkmode_actdet #(
  parameter int WIN       = 64,
  parameter int MIN_EDGES = 8
) (
  input  logic clk,
  input  logic ref_s,
  output logic ref_ok
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);
  localparam logic [CW-1:0] EDGE_MIN = CW'(MIN_EDGES);

  logic          ref_d    = 1'b0;
  logic [WW-1:0] win_cnt  = '0;
  logic [CW-1:0] edge_cnt = '0;
  logic          win_ok   = 1'b0;
  logic          ok_q     = 1'b0;
  logic          rise;

  assign rise = ref_s & ~ref_d;

  always_ff @(posedge clk) begin
    ref_d <= ref_s;
    if (win_cnt == WIN_LAST) begin
      win_cnt  <= '0;
      win_ok   <= (edge_cnt >= EDGE_MIN);
      edge_cnt <= CW'(rise);
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (rise && (edge_cnt != EDGE_MIN)) begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
    ok_q <= win_ok | (edge_cnt >= EDGE_MIN);
  end

  assign ref_ok = ok_q;
endmodule

// File: rtl/clkmode_decide.sv
// Latches the clocking mode on the cycle reset drops.
module clkmode_decide
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_ok,
  input  logic [1:0] id_n_s,
  output clk_mode_e  mode_q,
  output logic       primary_q,
  output logic       pll_en_q,
  output logic       pll_byp_q,
  output logic       bclk_oe_q,
  output logic [1:0] id_rpt_q,
  output logic [1:0] div_sel_q
);
  logic      rst_q = 1'b1;
  logic      capture;
  clk_mode_e nxt_mode;

  assign capture = ~rst & rst_q;

  always_comb begin
    if (ref_ok) begin
      nxt_mode = (id_n_s == STRAPS_HIGH) ? MODE_PLL_BYP : MODE_PLL;
    end else begin
      nxt_mode = (id_n_s == STRAPS_HIGH) ? MODE_XTAL : MODE_SEC;
    end
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      mode_q    <= MODE_SEC;
      primary_q <= 1'b0;
      pll_en_q  <= 1'b0;
      pll_byp_q <= 1'b0;
      bclk_oe_q <= 1'b0;
      id_rpt_q  <= 2'b00;
      div_sel_q <= 2'b00;
    end else if (capture) begin
      mode_q    <= nxt_mode;
      primary_q <= (nxt_mode != MODE_SEC);
      pll_en_q  <= (nxt_mode == MODE_PLL);
      pll_byp_q <= (nxt_mode == MODE_PLL_BYP);
      bclk_oe_q <= (nxt_mode != MODE_SEC);
      id_rpt_q  <= ref_ok ? 2'b00 : ~id_n_s;
      div_sel_q <= (nxt_mode == MODE_PLL) ? id_n_s : 2'b00;
    end
  end
endmodule

// File: rtl/clkmode_bclk.sv
// Divide-by-two bit clock, held low in reset or when not driving.
module clkmode_bclk (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bclk
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bclk <= 1'b0;
    end else begin
      bclk <= ~bclk;
    end
  end
endmodule

// File: rtl/clk_mode_select.sv
module clk_mode_select #(
  parameter int WIN_CYCLES  = 64,
  parameter int MIN_EDGES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_clk_i,
  input  logic [1:0] id_n_i,
  output logic [1:0] mode_o,
  output logic       primary_o,
  output logic       pll_en_o,
  output logic       pll_bypass_o,
  output logic       bclk_oe_o,
  output logic       bclk_o,
  output logic [1:0] id_rpt_o,
  output logic [1:0] pll_div_sel_o
);
  import clkmode_pkg::*;

  logic      ref_s;
  logic [1:0] id_n_s;
  logic      ref_ok;
  clk_mode_e mode_q;

  clkmode_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ref_sync (
    .clk (clk),
    .d   (ref_clk_i),
    .q   (ref_s)
  );

  clkmode_sync #(.W(2), .STAGES(SYNC_STAGES)) u_strap_sync (
    .clk (clk),
    .d   (id_n_i),
    .q   (id_n_s)
  );

  clkmode_actdet #(.WIN(WIN_CYCLES), .MIN_EDGES(MIN_EDGES)) u_actdet (
    .clk    (clk),
    .ref_s  (ref_s),
    .ref_ok (ref_ok)
  );

  clkmode_decide u_decide (
    .clk       (clk),
    .rst       (rst),
    .ref_ok    (ref_ok),
    .id_n_s    (id_n_s),
    .mode_q    (mode_q),
    .primary_q (primary_o),
    .pll_en_q  (pll_en_o),
    .pll_byp_q (pll_bypass_o),
    .bclk_oe_q (bclk_oe_o),
    .id_rpt_q  (id_rpt_o),
    .div_sel_q (pll_div_sel_o)
  );

  clkmode_bclk u_bclk (
    .clk  (clk),
    .rst  (rst),
    .en   (primary_o),
    .bclk (bclk_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/clkmode_checker.sv
module clkmode_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_o,
  input logic       primary_o,
  input logic       pll_en_o,
  input logic       pll_bypass_o,
  input logic       bclk_oe_o,
  input logic       bclk_o,
  input logic [1:0] id_rpt_o,
  input logic [1:0] pll_div_sel_o
);
  logic settled = 1'b0;

  always_ff @(posedge clk) begin
    settled <= ~rst;
  end

  AST_PLL_IMPLIES_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    (pll_en_o || pll_bypass_o) |-> primary_o); // R1

  AST_BYPASS_NO_DIVIDER: assert property (@(posedge clk) disable iff (rst)
    pll_bypass_o |-> (!pll_en_o && pll_div_sel_o == 2'b00)); // R2

  AST_ID_ZERO_WITH_REF: assert property (@(posedge clk) disable iff (rst)
    (pll_en_o || pll_bypass_o) |-> (id_rpt_o == 2'b00)); // R6

  AST_QUIET_WHEN_INPUT: assert property (@(posedge clk) disable iff (rst)
    !bclk_oe_o |-> !bclk_o); // R5

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    settled |=> ($stable(mode_o) && $stable(id_rpt_o) && $stable(primary_o))); // R7

  AST_BCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (primary_o && settled) |=> (bclk_o != $past(bclk_o))); // R8
endmodule

bind clk_mode_select clkmode_checker i_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_o        (mode_o),
  .primary_o     (primary_o),
  .pll_en_o      (pll_en_o),
  .pll_bypass_o  (pll_bypass_o),
  .bclk_oe_o     (bclk_oe_o),
  .bclk_o        (bclk_o),
  .id_rpt_o      (id_rpt_o),
  .pll_div_sel_o (pll_div_sel_o)
);

// File: tb/test_clk_mode_select.sv
`timescale 1ns/1ps
module test_clk_mode_select;
  localparam int WIN = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk = 1'b0;
  logic [1:0] id_n = 2'b11;
  logic [1:0] mode_o, id_rpt_o, pll_div_sel_o;
  logic       primary_o, pll_en_o, pll_bypass_o, bclk_oe_o, bclk_o;

  always #4 clk = ~clk;

  clk_mode_select #(.WIN_CYCLES(WIN), .MIN_EDGES(8), .SYNC_STAGES(2)) i_clk_mode_select (
    .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .id_n_i(id_n),
    .mode_o(mode_o), .primary_o(primary_o), .pll_en_o(pll_en_o),
    .pll_bypass_o(pll_bypass_o), .bclk_oe_o(bclk_oe_o), .bclk_o(bclk_o),
    .id_rpt_o(id_rpt_o), .pll_div_sel_o(pll_div_sel_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  // reference clock stimulus: half period in clk cycles, 0 = stopped
  int ref_half = 0;
  int ref_cnt = 0;
  always @(negedge clk) begin
    if (ref_half > 0) begin
      ref_cnt++;
      if (ref_cnt >= ref_half) begin
        ref_clk = ~ref_clk;
        ref_cnt = 0;
      end
    end
  end

  // scenario as decided at release
  bit         scen_ok = 1'b0;
  logic [1:0] scen_straps = 2'b11;
  bit         hold_phase = 1'b0;

  // behavioural model
  logic [1:0] e_mode = 2'b11, e_id = 2'b00, e_div = 2'b00;
  bit e_pri = 0, e_pll = 0, e_byp = 0, e_oe = 0, e_bclk = 0, in_rst = 1;
  bit m_prev_rst = 1'b1;
  int k = 0;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      e_mode = 2'b11; e_pri = 0; e_pll = 0; e_byp = 0; e_oe = 0;
      e_id = 2'b00; e_div = 2'b00; k = 0; in_rst = 1;
    end else if (m_prev_rst) begin
      in_rst = 0;
      k = 0;
      if (scen_ok) e_mode = (scen_straps == 2'b11) ? 2'b01 : 2'b10;
      else         e_mode = (scen_straps == 2'b11) ? 2'b00 : 2'b11;
      e_pri = (e_mode != 2'b11);
      e_pll = (e_mode == 2'b10);
      e_byp = (e_mode == 2'b01);
      e_oe  = e_pri;
      e_id  = scen_ok ? 2'b00 : ~scen_straps;
      e_div = (e_mode == 2'b10) ? scen_straps : 2'b00;
    end else begin
      k++;
    end
    e_bclk = (!rst && e_pri && (k % 2 == 1));
    m_prev_rst = rst;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string mode_tag();
    if (in_rst) return "R9";
    if (hold_phase) return "R7";
    case (e_mode)
      2'b00:   return "R4";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      string t;
      t = mode_tag();
      vectors++;
      chk(t, "mode_o", int'(mode_o), int'(e_mode));
      chk((scen_ok && !in_rst && !hold_phase) ? "R1" : t, "primary_o", int'(primary_o), int'(e_pri));
      chk(t, "pll_en_o", int'(pll_en_o), int'(e_pll));
      chk(t, "pll_bypass_o", int'(pll_bypass_o), int'(e_byp));
      chk(t, "bclk_oe_o", int'(bclk_oe_o), int'(e_oe));
      chk(in_rst ? "R9" : "R8", "bclk_o", int'(bclk_o), int'(e_bclk));
      chk(in_rst ? "R9" : "R6", "id_rpt_o", int'(id_rpt_o), int'(e_id));
      chk(in_rst ? "R9" : "R3", "pll_div_sel_o", int'(pll_div_sel_o), int'(e_div));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // kind: 0 = no reference, 1 = valid reference, 2 = too slow to count
  task automatic run_case(input int kind, input logic [1:0] straps, input int idx);
    @(negedge clk);
    hold_phase  = 1'b0;
    scen_ok     = (kind == 1);
    scen_straps = straps;
    id_n        = straps;
    ref_half    = (kind == 1) ? 3 : ((kind == 2) ? 20 : 0);
    rst         = 1'b1;
    repeat (4 * WIN) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    if (idx > 0) begin
      // R10: the mode is chosen anew at this release
      vectors++;
      chk("R10", "mode after re-reset", int'(mode_o), int'(e_mode));
    end
    repeat (20) @(negedge clk);
    // R7: late strap and reference activity must not change anything
    hold_phase = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      id_n     = 2'(i);
      ref_half = (i < 12) ? 3 : 0;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    miscompares++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9: reset values
    vectors++;
    chk("R9", "reset mode", int'(mode_o), 3);
    chk("R9", "reset bclk", int'(bclk_o), 0);
    run_case(1, 2'b11, 0);
    run_case(1, 2'b10, 1);
    run_case(1, 2'b01, 2);
    run_case(1, 2'b00, 3);
    run_case(0, 2'b11, 4);
    run_case(0, 2'b10, 5);
    run_case(0, 2'b01, 6);
    run_case(0, 2'b00, 7);
    run_case(2, 2'b11, 8);
    run_case(2, 2'b01, 9);
    run_case(1, 2'b11, 10);
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule